// File: doc/BRIEF.md
# Display Memory Byte Access Controller

This block sits between a host register decoder and a synchronous single-port memory that backs a 128 by 64 dot monochrome display. The memory is arranged as 16 column bytes per row and 64 picture rows, plus three extra rows for an auxiliary segment area. The block holds the column (X) and row (Y) address counters and turns each host byte access into one memory operation. It maps the logical column to a physical one, optionally mirrored, and can reverse the bit order of written bytes. After each access it advances the counters according to a stepping mode.

Writes are captured into a holding register at the host strobe and committed to memory in the next cycle. Reads go through a read latch. Each read hands back what the previous read fetched and starts a new fetch. So after any address load the first read is a dummy and real data follows from the second read on. The host keeps at least one idle cycle between strobes and never asserts both strobes together.

Top module: `gfx_access_ctrl`

## Requirements
- R1: After reset both counters are 0, the stepping mode is "no stepping" (code 0), no memory operation is issued and `rd_data` is 0. The first read after reset therefore returns 0.
- R2: The physical column is the logical X when `rev_cols`=0 and 15 minus X when `rev_cols`=1. The memory address is Y*16 plus the physical column: bits [10:4] hold Y and bits [3:0] hold the column.
- R3: With `swap_bits`=1, host bit i is stored as bit 7-i. With `swap_bits`=0 the byte is stored as given.
- R4: An in-range write strobe raises `ram_we` in the following cycle for exactly one cycle. The address and data of that commit are the ones present at the strobe.
- R5: A Y low-part load (`ld_ylo`, bits [3:0] of `ld_val`) only stages the value. The Y counter takes the staged low part together with the high part (`ld_val[2:0]`) when `ld_yhi` is pulsed.
- R6: Mode code bit 0 (`ld_val[0]` at `ld_mode`) alone steps X after each counted access, wrapping 15 to 0. The physical column therefore ascends when `rev_cols`=0 and descends when `rev_cols`=1.
- R7: Mode code bit 1 alone steps Y. Y wraps from 0x3F to 0x00 inside the picture area and from 0x42 to 0x40 inside the auxiliary area.
- R8: With both mode bits set, X steps on every counted access, and Y steps (with R7 wrapping) on the access at which X wraps from 15.
- R9: With mode bits [1:0] both 0, accesses never move the counters.
- R10: Mode bit 2 = 0 counts both reads and writes. Mode bit 2 = 1 counts only writes, so a read leaves the counters for a following modified write to the same byte.
- R11: A read strobe issues `ram_re` in the same cycle at the current address. The fetched byte appears on `rd_data` from the following read onward. Each read returns the byte fetched by the previous read, so the first read after an address load returns stale data.
- R12: When Y is above 0x42, a write or read issues no memory operation, leaves `rd_data` unchanged and moves no counter.
- R13: Loading the mode leaves both counters untouched. It suspends all stepping until the next X load or Y high-part load.
- R14: Host strobes are separated by at least one idle cycle and are never both high. Under that rule the memory never sees a write and a read in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_x | input | 1 | Load X counter from `ld_val[3:0]` |
| ld_ylo | input | 1 | Stage Y low part from `ld_val[3:0]` |
| ld_yhi | input | 1 | Load Y counter from `ld_val[2:0]` and staged low part |
| ld_mode | input | 1 | Load stepping mode from `ld_val[2:0]` |
| ld_val | input | 4 | Load value from the register decoder |
| rev_cols | input | 1 | Mirror the column order |
| swap_bits | input | 1 | Bit-reverse written bytes |
| wr_stb | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Host write byte |
| rd_stb | input | 1 | Host read strobe, one cycle |
| rd_data | output | 8 | Read latch contents |
| ram_addr | output | 11 | Memory address {Y, column} |
| ram_we | output | 1 | Memory write enable |
| ram_wdata | output | 8 | Memory write byte |
| ram_re | output | 1 | Memory read enable, data one cycle later |
| ram_rdata | input | 8 | Memory read byte |

## Verification
The bench builds the block with its default parameters: 16 columns, 64 picture rows and 3 auxiliary rows. This is small enough to sweep every byte of the picture area under all four combinations of column mirroring and bit reversal, first writing in linked stepping and then reading back with the dummy read. Directed sequences with hand-computed addresses then reach the wrap points of each stepping mode, the auxiliary rows, the out-of-range rows, the staged Y load, the suspension of stepping after a mode load, and the write-only counting used for read-modify-write.

// File: rtl/gfx_acc_pkg.sv
package gfx_acc_pkg;

    // kind of host access seen in a cycle
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_WR   = 2'd1,
        ACC_RD   = 2'd2
    } acc_kind_t;

    // stepping mode, loaded as ld_val[2:0]
    typedef struct packed {
        logic wr_only;   // bit 2: count writes only
        logic y_step;    // bit 1
        logic x_step;    // bit 0
    } step_mode_t;

    localparam int LD_W   = 4;  // width of the decoder load value
    localparam int YLO_W  = 4;  // width of the staged Y low part

endpackage

// File: rtl/gfx_addr_ctr.sv
module gfx_addr_ctr
    import gfx_acc_pkg::*;
#(
    parameter int XW        = 4,
    parameter int YW        = 7,
    parameter int MAIN_ROWS = 64,
    parameter int AUX_ROWS  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_x,
    input  logic            ld_ylo,
    input  logic            ld_yhi,
    input  logic            ld_mode,
    input  logic [LD_W-1:0] ld_val,
    input  acc_kind_t       acc,
    output logic [XW-1:0]   x_cnt,
    output logic [YW-1:0]   y_cnt,
    output logic            in_rng
);

    localparam int YHW = YW - YLO_W;
    localparam logic [XW-1:0] X_LAST      = '1;
    localparam logic [YW-1:0] Y_MAIN_LAST = YW'(MAIN_ROWS - 1);
    localparam logic [YW-1:0] Y_AUX_FIRST = YW'(MAIN_ROWS);
    localparam logic [YW-1:0] Y_LAST      = YW'(MAIN_ROWS + AUX_ROWS - 1);

    logic [XW-1:0]    x_q;
    logic [YW-1:0]    y_q;
    logic [YLO_W-1:0] ylo_stage_q;
    step_mode_t       mode_q;
    logic             armed_q;

    logic          any_ld;
    logic          counted;
    logic          do_step;
    logic          x_wrap;
    logic [YW-1:0] y_next;

    assign any_ld  = ld_x | ld_ylo | ld_yhi | ld_mode;
    assign in_rng  = (y_q <= Y_LAST);
    assign counted = (acc == ACC_WR) || ((acc == ACC_RD) && !mode_q.wr_only);
    assign do_step = armed_q && in_rng && counted;
    assign x_wrap  = (x_q == X_LAST);

    always_comb begin
        if (y_q == Y_MAIN_LAST)
            y_next = '0;
        else if (y_q == Y_LAST)
            y_next = Y_AUX_FIRST;
        else
            y_next = y_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q         <= '0;
            y_q         <= '0;
            ylo_stage_q <= '0;
            mode_q      <= '0;
            armed_q     <= 1'b1;
        end else begin
            if (do_step) begin
                if (mode_q.x_step)
                    x_q <= x_q + 1'b1;
                if (mode_q.y_step && (!mode_q.x_step || x_wrap))
                    y_q <= y_next;
            end
            if (ld_x) begin
                x_q     <= ld_val[XW-1:0];
                armed_q <= 1'b1;
            end
            if (ld_ylo)
                ylo_stage_q <= ld_val[YLO_W-1:0];
            if (ld_yhi) begin
                y_q     <= {ld_val[YHW-1:0], ylo_stage_q};
                armed_q <= 1'b1;
            end
            if (ld_mode) begin
                mode_q  <= step_mode_t'(ld_val[2:0]);
                armed_q <= 1'b0;
            end
        end
    end

    assign x_cnt = x_q;
    assign y_cnt = y_q;

    // R9
    idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!any_ld && !mode_q.x_step && !mode_q.y_step) |=> ($stable(x_q) && $stable(y_q)));

    // R10
    rd_no_count_chk: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD && mode_q.wr_only && !any_ld) |=> ($stable(x_q) && $stable(y_q)));

    // R13
    disarmed_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !ld_x && !ld_yhi) |=> ($stable(x_q) && $stable(y_q)));

    // R12
    oor_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_rng && !ld_x && !ld_yhi) |=> ($stable(x_q) && $stable(y_q)));

    // R7
    y_stays_in_rng_chk: assert property (@(posedge clk) disable iff (rst)
        (in_rng && !ld_yhi) |=> in_rng);

endmodule

// File: rtl/gfx_wr_hold.sv
module gfx_wr_hold #(
    parameter int DW = 8,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic          swap,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          we,
    output logic [AW-1:0] we_addr,
    output logic [DW-1:0] we_data
);

    logic [DW-1:0] flipped;
    logic [DW-1:0] store_val;
    logic          vld_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    for (genvar i = 0; i < DW; i++) begin : g_flip
        assign flipped[i] = wdata[DW-1-i];
    end

    assign store_val = swap ? flipped : wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            vld_q <= cap;
            if (cap) begin
                addr_q <= addr;
                data_q <= store_val;
            end
        end
    end

    assign we      = vld_q;
    assign we_addr = addr_q;
    assign we_data = data_q;

    // R4
    single_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !cap) |=> !vld_q);

endmodule

// File: rtl/gfx_rd_latch.sv
module gfx_rd_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch,
    input  logic [DW-1:0] ram_rdata,
    output logic [DW-1:0] rdata
);

    logic          pend_q;
    logic [DW-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            latch_q <= '0;
        end else begin
            pend_q <= fetch;
            if (pend_q)
                latch_q <= ram_rdata;
        end
    end

    assign rdata = latch_q;

    // R11
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> (rdata == $past(ram_rdata)));

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_q |=> $stable(rdata));

endmodule

// File: rtl/gfx_access_ctrl.sv
module gfx_access_ctrl
    import gfx_acc_pkg::*;
#(
    parameter int XW        = 4,
    parameter int YW        = 7,
    parameter int DW        = 8,
    parameter int MAIN_ROWS = 64,
    parameter int AUX_ROWS  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_x,
    input  logic            ld_ylo,
    input  logic            ld_yhi,
    input  logic            ld_mode,
    input  logic [LD_W-1:0] ld_val,
    input  logic            rev_cols,
    input  logic            swap_bits,
    input  logic            wr_stb,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_stb,
    output logic [DW-1:0]   rd_data,
    output logic [XW+YW-1:0] ram_addr,
    output logic            ram_we,
    output logic [DW-1:0]   ram_wdata,
    output logic            ram_re,
    input  logic [DW-1:0]   ram_rdata
);

    localparam int AW = XW + YW;
    localparam logic [XW-1:0] X_LAST = '1;

    acc_kind_t     acc;
    logic [XW-1:0] x_cnt;
    logic [YW-1:0] y_cnt;
    logic          in_rng;
    logic [XW-1:0] phys_x;
    logic [AW-1:0] cur_addr;
    logic          hold_we;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;

    always_comb begin
        if (wr_stb)
            acc = ACC_WR;
        else if (rd_stb)
            acc = ACC_RD;
        else
            acc = ACC_NONE;
    end

    gfx_addr_ctr #(
        .XW        (XW),
        .YW        (YW),
        .MAIN_ROWS (MAIN_ROWS),
        .AUX_ROWS  (AUX_ROWS)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .ld_x    (ld_x),
        .ld_ylo  (ld_ylo),
        .ld_yhi  (ld_yhi),
        .ld_mode (ld_mode),
        .ld_val  (ld_val),
        .acc     (acc),
        .x_cnt   (x_cnt),
        .y_cnt   (y_cnt),
        .in_rng  (in_rng)
    );

    assign phys_x   = rev_cols ? (X_LAST - x_cnt) : x_cnt;
    assign cur_addr = {y_cnt, phys_x};

    gfx_wr_hold #(
        .DW (DW),
        .AW (AW)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .cap     (wr_stb & in_rng),
        .swap    (swap_bits),
        .addr    (cur_addr),
        .wdata   (wr_data),
        .we      (hold_we),
        .we_addr (hold_addr),
        .we_data (hold_data)
    );

    assign ram_re    = rd_stb & ~wr_stb & in_rng;
    assign ram_we    = hold_we;
    assign ram_wdata = hold_data;
    assign ram_addr  = hold_we ? hold_addr : cur_addr;

    gfx_rd_latch #(
        .DW (DW)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .fetch     (ram_re),
        .ram_rdata (ram_rdata),
        .rdata     (rd_data)
    );

    // R14
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));

    // R14
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && rd_stb));

    // R14
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ram_we && ram_re));

    // R4
    wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && in_rng) |=> (ram_we && ram_addr == $past(cur_addr)));

    // R12
    oor_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !in_rng) |=> !ram_we);

endmodule

// File: tb/sim_gfx_access_ctrl.sv
module sim_gfx_access_ctrl;

    localparam int K_X = 0, K_YLO = 1, K_YHI = 2, K_MODE = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_x = 0, ld_ylo = 0, ld_yhi = 0, ld_mode = 0;
    logic [3:0]  ld_val = '0;
    logic        rev_cols = 0, swap_bits = 0;
    logic        wr_stb = 0, rd_stb = 0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [10:0] ram_addr;
    logic        ram_we, ram_re;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;

    logic [7:0]  mem [0:2047];
    logic [7:0]  shadow [0:1023];

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    gfx_access_ctrl u0 (
        .clk(clk), .rst(rst), .ld_x(ld_x), .ld_ylo(ld_ylo), .ld_yhi(ld_yhi),
        .ld_mode(ld_mode), .ld_val(ld_val), .rev_cols(rev_cols),
        .swap_bits(swap_bits), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_re(ram_re),
        .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    function automatic int phys(input int x, input int y, input bit rv);
        return y * 16 + (rv ? 15 - x : x);
    endfunction

    function automatic logic [7:0] brev(input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = d[7-i];
        return r;
    endfunction

    function automatic logic [7:0] pat(input int x, input int y, input int c);
        return 8'(((y * 7) + (x * 13) + (c * 61)) ^ 'h5A);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_ld(input int kind, input int val);
        @(negedge clk);
        ld_val = 4'(val);
        case (kind)
            K_X:    ld_x    = 1;
            K_YLO:  ld_ylo  = 1;
            K_YHI:  ld_yhi  = 1;
            default: ld_mode = 1;
        endcase
        @(negedge clk);
        ld_x = 0; ld_ylo = 0; ld_yhi = 0; ld_mode = 0;
    endtask

    task automatic set_xy(input int x, input int y);
        do_ld(K_X, x);
        do_ld(K_YLO, y % 16);
        do_ld(K_YHI, y / 16);
    endtask

    task automatic do_wr(input logic [7:0] d, output int we, output int a, output int w);
        @(negedge clk);
        wr_stb = 1; wr_data = d;
        @(negedge clk);
        wr_stb = 0;
        we = int'(ram_we); a = int'(ram_addr); w = int'(ram_wdata);
    endtask

    task automatic wr_exp(input string req, input logic [7:0] d, input int ea, input int ew);
        int we, a, w;
        do_wr(d, we, a, w);
        chk(req, we, 1);
        chk(req, a, ea);
        chk(req, w, ew);
    endtask

    task automatic do_rd(output int v, output int re, output int a);
        @(negedge clk);
        rd_stb = 1;
        #1;
        v = int'(rd_data); re = int'(ram_re); a = int'(ram_addr);
        @(negedge clk);
        rd_stb = 0;
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        int v, re, a, we, w, exp_w;
        for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 ram_we", int'(ram_we), 0);
        chk("R1 ram_re", int'(ram_re), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        do_rd(v, re, a);
        chk("R1 first read", v, 0);
        chk("R1 read addr", a, 0);
        // R9 mode 0 after reset: writes stay at 0
        wr_exp("R9 write0", 8'h11, 0, 8'h11);
        wr_exp("R9 write1", 8'h22, 0, 8'h22);

        // full sweeps: R2 R3 R4 R8 R11
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            rev_cols = c[0]; swap_bits = c[1];
            do_ld(K_MODE, 3);
            set_xy(0, 0);
            for (int yy = 0; yy < 64; yy++) begin
                for (int xx = 0; xx < 16; xx++) begin
                    logic [7:0] d;
                    d = pat(xx, yy, c);
                    exp_w = swap_bits ? int'(brev(d)) : int'(d);
                    do_wr(d, we, a, w);
                    chk("R4 commit", we, 1);
                    chk("R2 R8 addr", a, phys(xx, yy, rev_cols));
                    chk("R3 data", w, exp_w);
                    shadow[phys(xx, yy, rev_cols)] = 8'(exp_w);
                end
            end
            set_xy(0, 0);
            do_rd(v, re, a);
            chk("R11 dummy fetch", re, 1);
            chk("R11 dummy addr", a, phys(0, 0, rev_cols));
            for (int k = 0; k < 1024; k++) begin
                do_rd(v, re, a);
                chk("R11 readback", v, int'(shadow[phys(k % 16, k / 16, rev_cols)]));
            end
            // stale first read after load returns the last prefetch (0,0)
            do_ld(K_X, 5);
            do_rd(v, re, a);
            chk("R11 stale after load", v, int'(shadow[phys(0, 0, rev_cols)]));
        end

        @(negedge clk);
        rev_cols = 1; swap_bits = 0;

        // R6 X only, descending physical column under mirroring
        do_ld(K_MODE, 1);
        set_xy(14, 5);
        wr_exp("R6 x14", 8'h01, 5 * 16 + 1, 8'h01);
        wr_exp("R6 x15", 8'h02, 5 * 16 + 0, 8'h02);
        wr_exp("R6 wrap", 8'h03, 5 * 16 + 15, 8'h03);

        // R7 Y only
        do_ld(K_MODE, 2);
        set_xy(3, 'h3E);
        wr_exp("R7 y3E", 8'h04, 'h3E * 16 + 12, 8'h04);
        wr_exp("R7 y3F", 8'h05, 'h3F * 16 + 12, 8'h05);
        wr_exp("R7 wrap", 8'h06, 12, 8'h06);
        set_xy(3, 'h40);
        wr_exp("R7 aux40", 8'h07, 'h40 * 16 + 12, 8'h07);
        wr_exp("R7 aux41", 8'h08, 'h41 * 16 + 12, 8'h08);
        wr_exp("R7 aux42", 8'h09, 'h42 * 16 + 12, 8'h09);
        wr_exp("R7 aux wrap", 8'h0A, 'h40 * 16 + 12, 8'h0A);

        // R8 linked carry at row ends
        do_ld(K_MODE, 3);
        set_xy(15, 'h3F);
        wr_exp("R8 end", 8'h0B, 'h3F * 16 + 0, 8'h0B);
        wr_exp("R8 carry wrap", 8'h0C, 15, 8'h0C);
        set_xy(15, 'h42);
        wr_exp("R8 aux end", 8'h0D, 'h42 * 16 + 0, 8'h0D);
        wr_exp("R8 aux carry", 8'h0E, 'h40 * 16 + 15, 8'h0E);

        // R12 out-of-range row
        do_ld(K_MODE, 1);
        set_xy(3, 'h43);
        do_wr(8'hEE, we, a, w);
        chk("R12 write dropped", we, 0);
        do_rd(v, re, a);
        chk("R12 no fetch", re, 0);
        do_rd(w, re, a);
        chk("R12 latch kept", w, v);
        do_ld(K_YLO, 2);
        do_ld(K_YHI, 0);
        wr_exp("R12 x not stepped", 8'h10, 2 * 16 + 12, 8'h10);

        // R5 staged Y low part
        do_ld(K_YLO, 9);
        wr_exp("R5 low staged only", 8'h12, 2 * 16 + 11, 8'h12);
        do_ld(K_YHI, 1);
        wr_exp("R5 y applied", 8'h13, 'h19 * 16 + 10, 8'h13);

        // R13 mode load suspends stepping
        do_ld(K_MODE, 1);
        wr_exp("R13 held a", 8'h14, 'h19 * 16 + 9, 8'h14);
        wr_exp("R13 held b", 8'h15, 'h19 * 16 + 9, 8'h15);
        do_ld(K_X, 8);
        wr_exp("R13 resumed a", 8'h16, 'h19 * 16 + 7, 8'h16);
        wr_exp("R13 resumed b", 8'h17, 'h19 * 16 + 6, 8'h17);

        // R10 write-only counting for read-modify-write
        set_xy(0, 'h10);
        for (int i = 0; i < 4; i++)
            wr_exp("R6 prefill", 8'(8'hA0 + i), 'h10 * 16 + 15 - i, 8'hA0 + i);
        do_ld(K_MODE, 5);
        set_xy(1, 'h10);
        do_rd(v, re, a);
        chk("R10 dummy addr", a, 'h10 * 16 + 14);
        do_rd(v, re, a);
        chk("R10 read data", v, 'hA1);
        chk("R10 read no step", a, 'h10 * 16 + 14);
        do_rd(v, re, a);
        chk("R10 read again", v, 'hA1);
        wr_exp("R10 modify write", 8'hB1, 'h10 * 16 + 14, 8'hB1);
        wr_exp("R10 write steps", 8'hB2, 'h10 * 16 + 13, 8'hB2);
        do_ld(K_MODE, 1);
        set_xy(0, 'h10);
        do_rd(v, re, a);
        do_rd(v, re, a);
        chk("R10 read steps data", v, 'hA0);
        chk("R10 read steps addr", a, 'h10 * 16 + 14);
        do_rd(v, re, a);
        chk("R10 modified seen", v, 'hB1);

        // R9 mode 0 again
        do_ld(K_MODE, 0);
        set_xy(7, 3);
        wr_exp("R9 stay a", 8'h21, 3 * 16 + 8, 8'h21);
        wr_exp("R9 stay b", 8'h22, 3 * 16 + 8, 8'h22);

        done = 1;
        report();
    end

endmodule